// File: doc/BRIEF.md
# Eight-Level Interrupt Priority Controller

This block gathers eight interrupt request lines, holds them in a pending register, screens them through a mask register and an in-service register, and drives one interrupt line toward the processor. When the processor pulses the acknowledge input, the block picks the winning level and puts it on a 3-bit level output. It then moves that level from pending to in-service, or, in automatic-rotation mode, rotates priority instead.

Software controls the block through one byte-wide command port and one mask-load port. The command port carries two kinds of command word, told apart by bits [4:3]. One kind ends interrupts and moves the priority order. The other switches special mask mode, in which the in-service levels stop blocking other requests. The priority order is cyclic: one level is the lowest, and the level after it in cyclic order is the highest.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While reset is asserted, and right after it, the pending, in-service and mask registers are all zero, special mask mode and automatic rotation are off, and level 7 is the lowest priority, so level 0 is the highest. `int_out` is 0.
- R2: A pending bit is set on a rising edge of its `irq_in` line, as seen at a clock edge. A line that stays high does not set the bit again. Acknowledging a level clears its pending bit unless a new rising edge of that line arrives in the same cycle.
- R3: A `mask_we` pulse loads `mask_data` into the mask register, where bit i = 1 masks level i. A masked pending request never raises `int_out`, but it stays pending and takes part once it is unmasked.
- R4: A `cmd_we` pulse with `cmd_data[4:3]` = 00 is an end-of-interrupt/rotation command. With 01 it is a special-mask command. With 10 or 11 it changes nothing.
- R5: With special mask mode off, an unmasked pending level is allowed only if it has strictly higher priority than the highest-priority in-service level.
- R6: A special-mask command with bits [6:5] = 11 sets the mode and 10 clears it. 00 and 01 leave it unchanged. While the mode is set, only the mask blocks a pending request.
- R7: `int_out` is high exactly when at least one request is allowed. `ack_level` then shows the allowed level with the highest priority, and shows 0 otherwise. A rising clock edge with `ack` high sets that level's in-service bit. An acknowledge while `int_out` is low has no effect.
- R8: Operation code `cmd_data[7:5]` = 001 clears the highest-priority in-service bit. 011 clears the in-service bit numbered by `cmd_data[2:0]`.
- R9: Code 110 makes level `cmd_data[2:0]` the lowest priority. Code 111 does that and also clears the in-service bit of that level. Code 101 clears the highest-priority in-service bit and makes that level the lowest. If no level is in service, 101 does nothing.
- R10: Code 100 turns on automatic rotation and 000 turns it off. Code 010 does nothing. While automatic rotation is on, an acknowledge does not set an in-service bit. Instead it makes the acknowledged level the lowest priority.
- R11: An acknowledge and a command in the same cycle both take effect. The winner is chosen, and the end-of-interrupt target found, from the state before the edge. An in-service bit set by the acknowledge survives an end-of-interrupt aimed at the same level. A rotation commanded in that cycle overrides the automatic rotation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 8 | Interrupt request lines, latched on rising edges |
| cmd_we | input | 1 | Command write strobe |
| cmd_data | input | 8 | Command byte |
| mask_we | input | 1 | Mask register load strobe |
| mask_data | input | 8 | New mask value, 1 = masked |
| ack | input | 1 | Acknowledge strobe from the processor |
| int_out | output | 1 | Interrupt request to the processor |
| ack_level | output | 3 | Level that wins if acknowledged now |

## Verification
An acknowledge and a command write can land in the same clock cycle. When they do, the new in-service bit, the end-of-interrupt clear and two competing rotations all act on the same registers. The bench causes this on purpose: it issues a specific end-of-interrupt for the level being acknowledged, a rotating end-of-interrupt while automatic rotation is on, and a long pseudo-random stretch in which strobes overlap freely. A behavioural model applies the R11 ordering rules and is compared with `int_out` and `ack_level` on every cycle. Any wrong merge therefore shows up at the ports in the cycles that follow.

// File: rtl/pic_pkg.sv
package pic_pkg;

   localparam int CMD_W = 8;

   localparam logic [1:0] SEL_EOI = 2'b00;
   localparam logic [1:0] SEL_SMM = 2'b01;

   typedef enum logic [2:0] {
      OP_AROT_CLR = 3'b000,
      OP_NS_EOI   = 3'b001,
      OP_NOP      = 3'b010,
      OP_SP_EOI   = 3'b011,
      OP_AROT_SET = 3'b100,
      OP_ROT_NS   = 3'b101,
      OP_SET_PRI  = 3'b110,
      OP_ROT_SP   = 3'b111
   } eoi_op_e;

   typedef struct packed {
      logic       arot_set;
      logic       arot_clr;
      logic       eoi_top;
      logic       eoi_named;
      logic       rot_top;
      logic       rot_named;
      logic       smm_wr;
      logic       smm_val;
      logic [2:0] lvl;
   } pic_cmd_t;

endpackage

// File: rtl/pic_cmd_dec.sv
module pic_cmd_dec
   import pic_pkg::*;
(
   input  logic             we,
   input  logic [CMD_W-1:0] data,
   output pic_cmd_t         cmd
);

   always_comb begin
      cmd     = '0;
      cmd.lvl = data[2:0];
      if (we && data[4:3] == SEL_EOI) begin
         case (eoi_op_e'(data[7:5]))
            OP_AROT_CLR: cmd.arot_clr = 1'b1;
            OP_AROT_SET: cmd.arot_set = 1'b1;
            OP_NS_EOI:   cmd.eoi_top  = 1'b1;
            OP_ROT_NS:   begin cmd.eoi_top = 1'b1; cmd.rot_top = 1'b1; end
            OP_SP_EOI:   cmd.eoi_named = 1'b1;
            OP_SET_PRI:  cmd.rot_named = 1'b1;
            OP_ROT_SP:   begin cmd.eoi_named = 1'b1; cmd.rot_named = 1'b1; end
            default:     ;
         endcase
      end
      if (we && data[4:3] == SEL_SMM && data[6]) begin
         cmd.smm_wr  = 1'b1;
         cmd.smm_val = data[5];
      end
   end

endmodule

// File: rtl/pic_prio_pick.sv
module pic_prio_pick #(
   parameter int N_LVL = 8,
   localparam int LVL_W = $clog2(N_LVL)
) (
   input  logic [N_LVL-1:0] vec,
   input  logic [LVL_W-1:0] low,
   output logic             found,
   output logic [LVL_W-1:0] lvl
);

   logic [LVL_W-1:0] idx;

   // scan from lowest rank to highest so the highest-priority hit is kept last
   always_comb begin
      found = 1'b0;
      lvl   = '0;
      idx   = '0;
      for (int k = N_LVL - 1; k >= 0; k--) begin
         idx = low + LVL_W'(1) + LVL_W'(k);
         if (vec[idx]) begin
            found = 1'b1;
            lvl   = idx;
         end
      end
   end

endmodule

// File: rtl/pic_block_mask.sv
module pic_block_mask #(
   parameter int N_LVL = 8,
   localparam int LVL_W = $clog2(N_LVL)
) (
   input  logic [LVL_W-1:0] low,
   input  logic [LVL_W-1:0] top,
   input  logic             top_vld,
   input  logic             smm,
   output logic [N_LVL-1:0] allow
);

   logic [LVL_W-1:0] rank_t;
   assign rank_t = top - low - LVL_W'(1);

   for (genvar i = 0; i < N_LVL; i++) begin : g_lvl
      logic [LVL_W-1:0] rank_i;
      assign rank_i   = LVL_W'(i) - low - LVL_W'(1);
      assign allow[i] = smm | ~top_vld | (rank_i < rank_t);
   end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import pic_pkg::*;
#(
   parameter int N_LVL = 8,
   localparam int LVL_W = $clog2(N_LVL)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_LVL-1:0] irq_in,
   input  logic             cmd_we,
   input  logic [CMD_W-1:0] cmd_data,
   input  logic             mask_we,
   input  logic [N_LVL-1:0] mask_data,
   input  logic             ack,
   output logic             int_out,
   output logic [LVL_W-1:0] ack_level
);

   if (N_LVL < 2 || N_LVL > 8 || (N_LVL & (N_LVL - 1)) != 0) begin : g_bad_lvl
      $error("prio_irq_ctrl: N_LVL must be a power of two from 2 to 8");
   end

   logic [N_LVL-1:0] irq_prev, irr_q, imr_q, isr_q;
   logic [LVL_W-1:0] low_q;
   logic             smm_q, arot_q;

   pic_cmd_t cmd;
   pic_cmd_dec u_dec (.we(cmd_we), .data(cmd_data), .cmd(cmd));

   logic [LVL_W-1:0] cmd_lvl;
   assign cmd_lvl = cmd.lvl[LVL_W-1:0];

   logic             isr_vld;
   logic [LVL_W-1:0] isr_top;
   pic_prio_pick #(.N_LVL(N_LVL)) u_isr_top (
      .vec(isr_q), .low(low_q), .found(isr_vld), .lvl(isr_top));

   logic [N_LVL-1:0] allow, cand;
   pic_block_mask #(.N_LVL(N_LVL)) u_blk (
      .low(low_q), .top(isr_top), .top_vld(isr_vld), .smm(smm_q), .allow(allow));

   assign cand = irr_q & ~imr_q & allow;

   logic             win_vld;
   logic [LVL_W-1:0] win_lvl;
   pic_prio_pick #(.N_LVL(N_LVL)) u_win (
      .vec(cand), .low(low_q), .found(win_vld), .lvl(win_lvl));

   assign int_out   = win_vld;
   assign ack_level = win_vld ? win_lvl : '0;

   logic             ack_go, cmd_rot;
   logic [N_LVL-1:0] win_oh, top_oh, lvl_oh, rise;
   logic [N_LVL-1:0] irr_n, isr_clr, isr_set, isr_n;
   logic [LVL_W-1:0] low_n;

   always_comb begin
      ack_go  = ack & win_vld;
      win_oh  = N_LVL'(1) << win_lvl;
      top_oh  = N_LVL'(1) << isr_top;
      lvl_oh  = N_LVL'(1) << cmd_lvl;
      rise    = irq_in & ~irq_prev;
      irr_n   = (irr_q & ~({N_LVL{ack_go}} & win_oh)) | rise;
      isr_clr = ({N_LVL{cmd.eoi_top & isr_vld}} & top_oh)
              | ({N_LVL{cmd.eoi_named}} & lvl_oh);
      isr_set = {N_LVL{ack_go & ~arot_q}} & win_oh;
      isr_n   = (isr_q & ~isr_clr) | isr_set;
      cmd_rot = (cmd.rot_top & isr_vld) | cmd.rot_named;
      if (cmd.rot_top && isr_vld) low_n = isr_top;
      else if (cmd.rot_named)     low_n = cmd_lvl;
      else if (ack_go && arot_q)  low_n = win_lvl;
      else                        low_n = low_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_prev <= '0;
         irr_q    <= '0;
         imr_q    <= '0;
         isr_q    <= '0;
         low_q    <= LVL_W'(N_LVL - 1);
         smm_q    <= 1'b0;
         arot_q   <= 1'b0;
      end else begin
         irq_prev <= irq_in;
         irr_q    <= irr_n;
         isr_q    <= isr_n;
         low_q    <= low_n;
         if (mask_we)      imr_q  <= mask_data;
         if (cmd.smm_wr)   smm_q  <= cmd.smm_val;
         if (cmd.arot_set) arot_q <= 1'b1;
         if (cmd.arot_clr) arot_q <= 1'b0;
      end
   end

   logic unused_rot;
   assign unused_rot = cmd_rot;

endmodule

// File: rtl/pic_chk.sv
module pic_chk #(
   parameter int N_LVL = 8,
   localparam int LVL_W = $clog2(N_LVL)
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_LVL-1:0] irq_in,
   input logic             cmd_we,
   input logic [7:0]       cmd_data,
   input logic             ack,
   input logic             int_out,
   input logic [LVL_W-1:0] ack_level,
   input logic [N_LVL-1:0] irr_q,
   input logic [N_LVL-1:0] imr_q,
   input logic [N_LVL-1:0] isr_q,
   input logic [LVL_W-1:0] low_q,
   input logic             smm_q,
   input logic             arot_q
);

   // R1: reset leaves an idle controller
   a_r1_reset_idle: assert property (@(posedge clk)
      !rst_n |=> (irr_q == '0 && isr_q == '0 && imr_q == '0 && !smm_q && !arot_q
                  && low_q == LVL_W'(N_LVL - 1)));

   // R2: the acknowledged pending bit is gone unless the line rose again
   a_r2_ack_clears_req: assert property (@(posedge clk) disable iff (!rst_n)
      ack && int_out && !irq_in[ack_level] |=> !irr_q[$past(ack_level)]);

   // R3: the interrupt line needs an unmasked pending bit
   a_r3_int_needs_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
      int_out |-> (|(irr_q & ~imr_q)));

   // R4: reserved selector codes leave the mode flags alone
   a_r4_reserved_sel: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_we && cmd_data[4] |=> (smm_q == $past(smm_q) && arot_q == $past(arot_q)));

   // R5: without special mask mode the winner is never already in service
   a_r5_nested_block: assert property (@(posedge clk) disable iff (!rst_n)
      !smm_q && int_out |-> !isr_q[ack_level]);

   // R6: in special mask mode only the mask gates requests
   a_r6_smm_mask_only: assert property (@(posedge clk) disable iff (!rst_n)
      smm_q |-> (int_out == (|(irr_q & ~imr_q))));

   // R7: an acknowledge marks the winner in service
   a_r7_ack_in_service: assert property (@(posedge clk) disable iff (!rst_n)
      ack && int_out && !arot_q && !cmd_we |=> isr_q[$past(ack_level)]);

   // R8: a specific EOI clears its bit
   a_r8_specific_eoi: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_we && cmd_data[4:3] == 2'b00 && cmd_data[7:5] == 3'b011 && !(ack && int_out)
      |=> !isr_q[$past(cmd_data[2:0])]);

   // R10: automatic rotation leaves in-service untouched and rotates to the winner
   a_r10_auto_rotate: assert property (@(posedge clk) disable iff (!rst_n)
      arot_q && ack && int_out && !cmd_we
      |=> (isr_q == $past(isr_q) && low_q == $past(ack_level)));

endmodule

bind prio_irq_ctrl pic_chk #(.N_LVL(N_LVL)) u_chk (
   .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cmd_we(cmd_we), .cmd_data(cmd_data),
   .ack(ack), .int_out(int_out), .ack_level(ack_level), .irr_q(irr_q), .imr_q(imr_q),
   .isr_q(isr_q), .low_q(low_q), .smm_q(smm_q), .arot_q(arot_q));

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] irq = '0;
   logic       cmd_we = 1'b0;
   logic [7:0] cmd_data = '0;
   logic       mask_we = 1'b0;
   logic [7:0] mask_data = '0;
   logic       ack = 1'b0;
   logic       int_out;
   logic [2:0] ack_level;

   always #10 clk = ~clk;

   prio_irq_ctrl i_prio_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .irq_in(irq), .cmd_we(cmd_we), .cmd_data(cmd_data),
      .mask_we(mask_we), .mask_data(mask_data), .ack(ack),
      .int_out(int_out), .ack_level(ack_level));

   int    n_vec = 0;
   int    n_bad = 0;
   string tag = "R1";

   // behavioural reference state
   logic [7:0] m_irr, m_imr, m_isr, m_prev;
   int         m_low;
   bit         m_smm, m_arot;

   function automatic int rank(int i);
      return (i - m_low - 1 + 16) % 8;
   endfunction

   function automatic int best(logic [7:0] v);
      int b = -1;
      for (int i = 0; i < 8; i++)
         if (v[i] && (b < 0 || rank(i) < rank(b))) b = i;
      return b;
   endfunction

   function automatic logic [7:0] allowed();
      logic [7:0] r = '0;
      int t = best(m_isr);
      for (int i = 0; i < 8; i++) begin
         r[i] = m_irr[i] & ~m_imr[i];
         if (!m_smm && t >= 0 && rank(i) >= rank(t)) r[i] = 1'b0;
      end
      return r;
   endfunction

   task automatic model_reset();
      m_irr = '0; m_imr = '0; m_isr = '0; m_prev = '0;
      m_low = 7; m_smm = 0; m_arot = 0;
   endtask

   task automatic model_clock();
      logic [7:0] rise, n_irr, n_isr;
      int w, t, n_low, op, sel, nm;
      bit go;
      rise = irq & ~m_prev;
      w = best(allowed());
      go = ack && (w >= 0);
      t = best(m_isr);
      op = int'(cmd_data[7:5]); sel = int'(cmd_data[4:3]); nm = int'(cmd_data[2:0]);
      n_irr = m_irr;
      if (go) n_irr[w] = 1'b0;
      n_irr = n_irr | rise;
      n_isr = m_isr;
      n_low = m_low;
      if (go && m_arot) n_low = w;
      if (cmd_we && sel == 0) begin
         if ((op == 1 || op == 5) && t >= 0) n_isr[t] = 1'b0;
         if (op == 3 || op == 7) n_isr[nm] = 1'b0;
      end
      if (go && !m_arot) n_isr[w] = 1'b1;
      if (cmd_we && sel == 0) begin
         if (op == 5 && t >= 0) n_low = t;
         if (op == 6 || op == 7) n_low = nm;
         if (op == 0) m_arot = 0;
         if (op == 4) m_arot = 1;
      end
      if (cmd_we && sel == 1 && cmd_data[6]) m_smm = cmd_data[5];
      if (mask_we) m_imr = mask_data;
      m_irr = n_irr; m_isr = n_isr; m_low = n_low; m_prev = irq;
   endtask

   task automatic check(string what, int act, int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic step();
      int w;
      #2;
      w = best(allowed());
      check("int_out", int'(int_out), (w >= 0) ? 1 : 0);
      check("ack_level", int'(ack_level), (w >= 0) ? w : 0);
      @(posedge clk);
      if (rst_n) model_clock(); else model_reset();
      @(negedge clk);
      cmd_we = 1'b0; ack = 1'b0; mask_we = 1'b0;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic cmd(logic [7:0] d);
      cmd_we = 1'b1; cmd_data = d; step();
   endtask

   task automatic acknowledge();
      ack = 1'b1; step();
   endtask

   task automatic load_mask(logic [7:0] m);
      mask_we = 1'b1; mask_data = m; step();
   endtask

   task automatic expect_out(int e_int, int e_lvl);
      #2;
      check("int_out direct", int'(int_out), e_int);
      check("ack_level direct", int'(ack_level), e_lvl);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL R11 watchdog: got running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      model_reset();
      @(negedge clk);
      tag = "R1";
      irq = 8'h81;
      idle(3);
      expect_out(0, 0);
      rst_n = 1'b1;
      irq = 8'h00;
      idle(2);
      expect_out(0, 0);

      tag = "R2";
      irq = 8'h08; step();
      expect_out(1, 3);
      acknowledge();
      idle(2);
      expect_out(0, 0);
      tag = "R8";
      cmd(8'h20);
      irq = 8'h00; step();
      irq = 8'h08; step();
      expect_out(1, 3);
      tag = "R7";
      acknowledge();
      tag = "R8";
      cmd(8'h20);
      irq = 8'h00; step();
      tag = "R7";
      acknowledge();

      tag = "R3";
      load_mask(8'h20);
      irq = 8'h20; step();
      expect_out(0, 0);
      load_mask(8'h00);
      expect_out(1, 5);
      acknowledge();
      cmd(8'h20);
      irq = 8'h00; step();

      tag = "R5";
      irq = 8'h08; step();
      acknowledge();
      irq = 8'h3A; step();
      expect_out(1, 1);
      acknowledge();
      expect_out(0, 0);
      cmd(8'h20);
      expect_out(0, 0);
      cmd(8'h20);
      expect_out(1, 4);

      tag = "R6";
      irq = 8'h00; step();
      acknowledge();
      cmd(8'h68);
      expect_out(1, 5);
      cmd(8'h28);
      expect_out(1, 5);
      cmd(8'h48);
      expect_out(0, 0);
      tag = "R4";
      cmd(8'h78);
      expect_out(0, 0);
      cmd(8'h50);
      cmd(8'hF0);
      expect_out(0, 0);
      tag = "R6";
      cmd(8'h68);
      acknowledge();
      cmd(8'h48);

      tag = "R8";
      cmd(8'h64);
      cmd(8'h63);
      cmd(8'h20);
      cmd(8'h20);
      idle(1);
      expect_out(0, 0);

      tag = "R9";
      irq = 8'h11; step();
      cmd(8'hC3);
      expect_out(1, 4);
      cmd(8'hC4);
      expect_out(1, 0);
      acknowledge();
      cmd(8'hA0);
      expect_out(1, 4);
      cmd(8'hA0);
      acknowledge();
      cmd(8'hE4);
      irq = 8'h00; step();

      tag = "R10";
      cmd(8'h80);
      irq = 8'h0F; step();
      acknowledge();
      acknowledge();
      cmd(8'h40);
      acknowledge();
      cmd(8'h00);
      acknowledge();
      cmd(8'h20);
      tag = "R7";
      acknowledge();
      acknowledge();
      expect_out(0, 0);

      tag = "R11";
      irq = 8'h00; step();
      irq = 8'h06; step();
      ack = 1'b1; cmd_we = 1'b1; cmd_data = 8'h61; step();
      cmd(8'h20);
      cmd(8'h80);
      ack = 1'b1; cmd_we = 1'b1; cmd_data = 8'hC5; step();
      irq = 8'h00; step();
      irq = 8'h08; ack = 1'b1; step();
      cmd(8'h00);

      begin
         logic [15:0] lf = 16'hACE1;
         for (int i = 0; i < 3000; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            irq = irq ^ (lf[7:0] & {7'b0, lf[9]} << lf[12:10]);
            ack = lf[3] & lf[5];
            if (lf[11] & lf[14]) begin
               cmd_we = 1'b1;
               cmd_data = {lf[15:13], lf[2] & lf[6], lf[4] & lf[1], lf[8:6]};
            end
            if (lf[0] & lf[2] & lf[9]) begin
               mask_we = 1'b1;
               mask_data = lf[15:8] & lf[7:0];
            end
            step();
         end
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule